// File: doc/BRIEF.md
# Double-Buffered Gamma Table Controller

This block applies a per-channel gamma curve to an RGB pixel stream. The curve is held in a lookup table with two banks. Software reloads one bank through a small register port while the other bank keeps serving pixels, so a new curve never shows up half-loaded on screen. In lookup mode, each output channel is the stored entry addressed by the upper `IDX_W` bits of that channel's input value. In bypass mode, the pixel is copied through unchanged.

Loading uses a write pointer that advances by itself. Software sets the pointer once, then streams values into the data register. A 3-bit colour mask decides which channel tables each write updates. Software can therefore load a grey curve into all three channels in one pass, or load each channel separately. A full load is `2**IDX_W` base entries plus one closing entry. The requested mode and the bank to display are latched into the active state only on a frame-start pulse. The status field reports that active state.

Top module: `gamma_lut_ctrl`

## Requirements
- R1: After reset, `out_valid` and the output channels are 0. Every register field reads back 0 except the write colour mask, which reads back 7.
- R2: While the active mode is not 2, each valid pixel appears on the outputs unchanged. This includes active mode 0, which is bypass.
- R3: `out_valid` is `pix_valid` delayed by exactly one clock. Each valid pixel yields exactly one output, and outputs come out in input order.
- R4: While the active mode is 2 (table lookup), each output channel equals the stored entry of the active bank for that channel. The entry is addressed by input bits `[PIX_W-1 -: IDX_W]` of the same channel.
- R5: A write to the data register (address 2, value in bits `[PIX_W-1:0]`) stores at the current write pointer and then increments the pointer by one.
- R6: A write to the index register (address 1, bits `[PTR_W-1:0]`) sets the write pointer. Reading address 1 returns the pointer. Written values above `2**IDX_W` set the pointer to 0.
- R7: The lookup-control register (address 3) holds the write colour mask in bits `[2:0]`. Bit 2 enables red, bit 1 enables green and bit 0 enables blue. A data write leaves the tables of unmasked channels unchanged.
- R8: Bit 4 of the lookup-control register selects the bank that data writes go to: 0 is bank A and 1 is bank B.
- R9: The control register (address 0) takes the requested mode in bits `[1:0]` and the next bank (0 = A, 1 = B) in bit 4. These fields read back at the same positions. The active mode (read in bits `[9:8]`) and the active bank (read in bit 12) take the requested values only on a `frame_start` pulse. Until then, the requested values have no effect on the pixel path.
- R10: After the data write at the last entry (`2**IDX_W`), the pointer wraps to 0, and the next data write lands in entry 0.
- R11: A data write into the bank that is currently active takes effect for the pixels that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 index, 2 data, 3 lookup control) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Read data for `reg_addr`, combinational |
| frame_start | input | 1 | Frame boundary pulse; latches the requested mode and bank |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | PIX_W | Input red |
| pix_g | input | PIX_W | Input green |
| pix_b | input | PIX_W | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | PIX_W | Output red |
| out_g | output | PIX_W | Output green |
| out_b | output | PIX_W | Output blue |

## Verification
The checker enforces the following rules on every cycle:
- the one-clock valid delay;
- pass-through while the active mode is not lookup;
- the pointer step and its wrap;
- the active mode and bank staying put except across a frame-start pulse.

Other behaviour can only be shown by the bench's scenarios:
- table contents under each colour mask;
- the separation between banks;
- a write into the live bank becoming visible;
- a requested mode having no effect before the frame boundary.

The bench covers these by keeping its own model of both banks and checking every output pixel against it.

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl #(
  parameter int PIX_W = 12,
  parameter int IDX_W = 6,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_r,
  input  logic [PIX_W-1:0] pix_g,
  input  logic [PIX_W-1:0] pix_b,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b
);
  localparam int DEPTH  = (1 << IDX_W) + 1;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int MEM_AW = $clog2(2 * DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [1:0] MODE_RAM = 2'd2;

  logic [1:0]       req_mode, act_mode;
  logic             req_sel, act_bank;
  logic [2:0]       wr_mask;
  logic             host_sel;
  logic [PTR_W-1:0] wr_idx;
  logic             unused_wbits;

  wire data_wr = reg_wr && reg_addr == 2'd2;
  wire [MEM_AW-1:0] wr_addr = (host_sel ? MEM_AW'(DEPTH) : '0) + MEM_AW'(wr_idx);
  wire [MEM_AW-1:0] rd_base = act_bank ? MEM_AW'(DEPTH) : '0;

  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_mode <= '0;
      req_sel  <= 1'b0;
      wr_mask  <= 3'b111;
      host_sel <= 1'b0;
      wr_idx   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: begin
          req_mode <= reg_wdata[1:0];
          req_sel  <= reg_wdata[4];
        end
        2'd1: wr_idx <= (reg_wdata[PTR_W-1:0] > LAST) ? '0 : reg_wdata[PTR_W-1:0];
        2'd2: wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
        default: begin
          wr_mask  <= reg_wdata[2:0];
          host_sel <= reg_wdata[4];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= '0;
      act_bank <= 1'b0;
    end else if (frame_start) begin
      act_mode <= req_mode;
      act_bank <= req_sel;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[1:0] = req_mode;
        reg_rdata[4]   = req_sel;
        reg_rdata[9:8] = act_mode;
        reg_rdata[12]  = act_bank;
      end
      2'd1: reg_rdata[PTR_W-1:0] = wr_idx;
      2'd3: begin
        reg_rdata[2:0] = wr_mask;
        reg_rdata[4]   = host_sel;
      end
      default: reg_rdata = '0;
    endcase
  end

  logic [PIX_W-1:0] pin  [3];
  logic [PIX_W-1:0] pout [3];
  assign pin[0] = pix_r;
  assign pin[1] = pix_g;
  assign pin[2] = pix_b;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [PIX_W-1:0] tbl [2*DEPTH];
    logic [PIX_W-1:0] q;

    always_ff @(posedge clk)
      if (data_wr && wr_mask[2-c]) tbl[wr_addr] <= reg_wdata[PIX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (pix_valid)
        q <= (act_mode == MODE_RAM) ? tbl[rd_base + MEM_AW'(pin[c][PIX_W-1 -: IDX_W])] : pin[c];
    end

    assign pout[c] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= pix_valid;
  end

  assign out_r = pout[0];
  assign out_g = pout[1];
  assign out_b = pout[2];
endmodule

// File: rtl/gamma_lut_ctrl_chk.sv
module gamma_lut_ctrl_chk #(
  parameter int PIX_W = 12,
  parameter int PTR_W = 7,
  parameter int DEPTH = 65
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_r,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_r,
  input logic             frame_start,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [1:0]       req_mode,
  input logic             req_sel,
  input logic [1:0]       act_mode,
  input logic             act_bank,
  input logic [PTR_W-1:0] wr_idx
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  p_valid_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  p_bypass_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && act_mode != 2'd2) |=> out_r == $past(pix_r));
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && wr_idx != LAST) |=> wr_idx == $past(wr_idx) + 1'b1);
  p_ptr_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && wr_idx == LAST) |=> wr_idx == '0);
  p_hold_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_mode) && $stable(act_bank)));
  p_latch_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_mode == $past(req_mode) && act_bank == $past(req_sel)));
endmodule

bind gamma_lut_ctrl gamma_lut_ctrl_chk #(
  .PIX_W(PIX_W), .PTR_W(PTR_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_r(pix_r),
  .out_valid(out_valid), .out_r(out_r), .frame_start(frame_start),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .req_mode(req_mode), .req_sel(req_sel),
  .act_mode(act_mode), .act_bank(act_bank), .wr_idx(wr_idx)
);

// File: tb/gamma_lut_ctrl_bench.sv
module gamma_lut_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 12;
  localparam int IDX_W = 6;
  localparam int DEPTH = (1 << IDX_W) + 1;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, frame_start = 0, pix_valid = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [PIX_W-1:0] pix_r = 0, pix_g = 0, pix_b = 0, out_r, out_g, out_b;
  logic out_valid;

  gamma_lut_ctrl #(.PIX_W(PIX_W), .IDX_W(IDX_W), .REG_W(32)) u_gamma_lut_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int model [2][3][DEPTH];
  int m_req_mode = 0, m_req_sel = 0, m_act_mode = 0, m_act_bank = 0;
  int m_mask = 7, m_hsel = 0, m_idx = 0;
  logic [3*PIX_W-1:0] exp_q [$];
  string tag_q [$];

  function automatic int look(int ch, logic [PIX_W-1:0] v);
    return (m_act_mode == 2) ? model[m_act_bank][ch][v >> (PIX_W - IDX_W)] : int'(v);
  endfunction

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    case (a)
      2'd0: begin m_req_mode = d & 3; m_req_sel = (d >> 4) & 1; end
      2'd1: m_idx = ((d & 127) > DEPTH - 1) ? 0 : (d & 127);
      2'd2: begin
        for (int c = 0; c < 3; c++)
          if (m_mask[2-c]) model[m_hsel][c][m_idx] = d & ((1 << PIX_W) - 1);
        m_idx = (m_idx == DEPTH - 1) ? 0 : m_idx + 1;
      end
      default: begin m_mask = d & 7; m_hsel = (d >> 4) & 1; end
    endcase
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== 32'(exp)) begin
      errors++;
      $display("FAIL %s: reg %0d got %h expected %h", tag, a, reg_rdata, 32'(exp));
    end
  endtask

  function automatic int ctrl_exp();
    return (m_act_bank << 12) | (m_act_mode << 8) | (m_req_sel << 4) | m_req_mode;
  endfunction

  task automatic frame();
    @(negedge clk);
    frame_start = 1;
    m_act_mode = m_req_mode; m_act_bank = m_req_sel;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic send(input logic [PIX_W-1:0] r, g, b, input string tag);
    @(negedge clk);
    pix_valid = 1; pix_r = r; pix_g = g; pix_b = b;
    exp_q.push_back({PIX_W'(look(0, r)), PIX_W'(look(1, g)), PIX_W'(look(2, b))});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3: output valid with no pixel pending, got 1 expected 0");
      end else begin
        logic [3*PIX_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_r, out_g, out_b} !== e) begin
          errors++;
          $display("FAIL %s: pixel got %h expected %h", t, {out_r, out_g, out_b}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || {out_r, out_g, out_b} !== '0) begin
      errors++;
      $display("FAIL R1: outputs got %b/%h expected 0/0", out_valid, {out_r, out_g, out_b});
    end
    rd_chk(2'd0, 0, "R1");
    rd_chk(2'd1, 0, "R1");
    rd_chk(2'd3, 7, "R1");

    // R2 R3: bypass, back-to-back and gapped
    send(12'h123, 12'h456, 12'h789, "R2");
    send(12'hFFF, 12'h000, 12'h800, "R3");
    idle(2);
    send(12'h0AB, 12'hCDE, 12'hF01, "R2");
    idle(2);

    // R8 R10: full load of bank B, all channels
    wr(2'd3, 16 | 7);
    wr(2'd1, 0);
    for (int i = 0; i < DEPTH; i++) wr(2'd2, i * 3);
    rd_chk(2'd1, 0, "R10");
    // R7: red only, then blue only
    wr(2'd3, 16 | 4);
    wr(2'd1, 0);
    for (int i = 0; i < DEPTH; i++) wr(2'd2, i * 5 + 1);
    wr(2'd3, 16 | 1);
    wr(2'd1, 0);
    for (int i = 0; i < DEPTH; i++) wr(2'd2, 4000 - i);
    rd_chk(2'd3, 16 | 1, "R7");
    // R8: bank A
    wr(2'd3, 7);
    wr(2'd1, 0);
    for (int i = 0; i < DEPTH; i++) wr(2'd2, i * 7 + 100);
    // R5 R6
    wr(2'd1, 10);
    rd_chk(2'd1, 10, "R6");
    wr(2'd1, 100);
    rd_chk(2'd1, 0, "R6");
    wr(2'd1, 5);
    wr(2'd2, 5 * 7 + 100);
    wr(2'd2, 6 * 7 + 100);
    rd_chk(2'd1, 7, "R5");

    // R9: request lookup on B, no frame start yet
    wr(2'd0, 16 | 2);
    rd_chk(2'd0, ctrl_exp(), "R9");
    send(12'h040, 12'h080, 12'hFC0, "R9");
    idle(2);
    frame();
    rd_chk(2'd0, ctrl_exp(), "R9");

    // R4 R7: lookup from bank B
    send(12'h000, 12'h000, 12'h000, "R4");
    send(12'hFFF, 12'hFFF, 12'hFFF, "R4");
    send(12'h7C5, 12'h3A0, 12'h13F, "R7");
    send(12'h040, 12'hA00, 12'h555, "R4");
    idle(2);

    // R8: switch to bank A
    wr(2'd0, 2);
    frame();
    send(12'h7C5, 12'h3A0, 12'h13F, "R8");
    send(12'hFC0, 12'h001, 12'h8FF, "R8");
    idle(2);

    // R10 R11: wrap while writing the live bank
    wr(2'd1, DEPTH - 1);
    wr(2'd2, 777);
    wr(2'd2, 888);
    rd_chk(2'd1, 1, "R10");
    send(12'h03F, 12'h000, 12'h020, "R11");
    idle(2);

    // R2: non-lookup mode 1 returns to pass-through
    wr(2'd0, 1);
    frame();
    send(12'h3A0, 12'h13F, 12'h7C5, "R2");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: pending pixels got %0d expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule